// File: doc/BRIEF.md
# Serial Word Bus Master

This block is the master end of a shared serial programming bus: one bus clock, one data line that either end may drive, and a set of per-target strobe lines. On a start request it captures a 24-bit word and a target number, then moves the word over the data line one bit per bus clock period, most significant bit first. Once the last bit period has ended, it raises the strobe line of the chosen target for half a bus clock period so that the target commits the word.

The same sequence also reads a word back. In receive mode the master never drives the data line. The slave places a bit after each falling bus clock edge, and the master samples it at the following falling edge. After the 24th bit the assembled word appears on the receive output. The bus clock is divided down from the system clock and runs all the time, whether or not a transfer is in progress. It is shared by every device on the bus. Each completed transfer sets a sticky interrupt flag.

Top module: `serial_word_master`

## Requirements
- R1: After reset, `busy`, `irq`, `bus_oe` and every `latch` line are 0, `rx_word` is 0 and `bus_clk` is 1.
- R2: `bus_clk` toggles every `HALF` system clock cycles, so its period is 2*`HALF` cycles, both while idle and during a transfer.
- R3: In transmit mode (`rx_mode`=0), the first 24 falling bus clock edges after a start each present one bit of the captured word on `bus_do`, starting with bit 23 and ending with bit 0. `bus_do` changes only at those edges, and `bus_oe` stays 1 across the 24 bit periods.
- R4: At the 25th falling edge after a start, `bus_oe` goes to 0 and only `latch[target]` goes to 1, where target is the value captured at the start. Target 0 drives `latch[0]`, target 3 drives `latch[3]`.
- R5: The strobe stays high for exactly `HALF` system clock cycles and ends at the next rising bus clock edge.
- R6: In receive mode (`rx_mode`=1), `bus_oe` stays 0 for the whole transfer. `bus_di` is sampled at falling edges 2 to 25, and the first sampled bit becomes bit 23 of `rx_word`. `rx_word` is updated when the strobe ends.
- R7: `busy` is 1 from the clock after `start` is accepted until the same edge at which the strobe ends.
- R8: `irq` is set when the strobe ends and stays set until `irq_clr` is applied. A completion in the same cycle as `irq_clr` leaves `irq` set.
- R9: A `start` while `busy` is 1 is ignored. Later changes to `tx_word` and `target` do not affect the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start request, accepted when idle |
| rx_mode | input | 1 | 0 selects transmit, 1 selects receive |
| target | input | TGT_W (2) | Strobe line to pulse at the end of the transfer |
| tx_word | input | WORD_W (24) | Word to send, bit 23 first |
| irq_clr | input | 1 | Clears the completion flag |
| bus_di | input | 1 | Data line as seen at the pin |
| bus_clk | output | 1 | Free-running bus clock |
| bus_do | output | 1 | Data driven onto the line |
| bus_oe | output | 1 | Drive enable for the data line |
| latch | output | NUM_LATCH (4) | Per-target commit strobes |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Sticky completion flag |
| rx_word | output | WORD_W (24) | Last word received |

## Verification
The assertions assume that reset is applied from time zero. They also assume that `bus_di`, `start`, `target` and `irq_clr` are synchronous to `clk`, because the stable-data check and the flag check compare values one system clock apart. The bench changes every input only at falling `clk` edges. It drives `bus_di` right after it observes a falling bus clock edge, so the bit is settled a full bus period before the master samples it. It reads `latch`, `bus_do` and `bus_oe` at the same falling `clk` edges.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_SHIFT  = 2'd1,
      SEQ_STROBE = 2'd2
   } seq_state_e;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/sbm_clkgen.sv
module sbm_clkgen #(
   parameter int HALF = 50
) (
   input  logic clk,
   input  logic rst_n,
   output logic bus_clk,
   output logic fall_ev,
   output logic rise_ev
);

   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CW-1:0] cnt_q;
   logic          wrap;

   assign wrap    = (cnt_q == CW'(HALF - 1));
   assign fall_ev = wrap & bus_clk;
   assign rise_ev = wrap & ~bus_clk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         bus_clk <= 1'b1;
      end else if (wrap) begin
         cnt_q   <= '0;
         bus_clk <= ~bus_clk;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/sbm_seq.sv
module sbm_seq
   import sbm_pkg::*;
#(
   parameter int WORD_W = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fall_ev,
   input  logic rise_ev,
   input  logic start,
   input  logic rx_mode,
   output logic busy,
   output logic oe,
   output logic load,
   output logic shift_out,
   output logic shift_in,
   output logic strobe,
   output logic done,
   output logic rx_act
);

   localparam int BW = $clog2(WORD_W + 1) + 1;

   seq_state_e    st_q;
   logic [BW-1:0] nbit_q;
   logic          mode_q;
   logic          oe_q;
   logic          last;

   assign last = (nbit_q == BW'(WORD_W));

   always_comb begin
      load      = (st_q == SEQ_IDLE) & start;
      shift_out = (st_q == SEQ_SHIFT) & fall_ev & ~last & ~mode_q;
      shift_in  = (st_q == SEQ_SHIFT) & fall_ev & (nbit_q != '0) & mode_q;
      done      = (st_q == SEQ_STROBE) & rise_ev;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SEQ_IDLE;
         nbit_q <= '0;
         mode_q <= 1'b0;
         oe_q   <= 1'b0;
      end else begin
         case (st_q)
            SEQ_IDLE: begin
               if (start) begin
                  st_q   <= SEQ_SHIFT;
                  nbit_q <= '0;
                  mode_q <= rx_mode;
               end
            end
            SEQ_SHIFT: begin
               if (fall_ev) begin
                  if (last) begin
                     st_q <= SEQ_STROBE;
                     oe_q <= 1'b0;
                  end else begin
                     nbit_q <= nbit_q + 1'b1;
                     oe_q   <= ~mode_q;
                  end
               end
            end
            SEQ_STROBE: begin
               if (rise_ev) st_q <= SEQ_IDLE;
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy   = (st_q != SEQ_IDLE);
   assign strobe = (st_q == SEQ_STROBE);
   assign oe     = oe_q;
   assign rx_act = mode_q;

endmodule

// File: rtl/sbm_shifter.sv
module sbm_shifter #(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] par_in,
   input  logic              shift_out,
   input  logic              shift_in,
   input  logic              ser_in,
   output logic              ser_out,
   output logic [WORD_W-1:0] par_out
);

   logic [WORD_W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q    <= '0;
         ser_out <= 1'b0;
      end else if (load) begin
         sr_q <= par_in;
      end else if (shift_out) begin
         ser_out <= sr_q[WORD_W-1];
         sr_q    <= {sr_q[WORD_W-2:0], 1'b0};
      end else if (shift_in) begin
         sr_q <= {sr_q[WORD_W-2:0], ser_in};
      end
   end

   assign par_out = sr_q;

endmodule

// File: rtl/serial_word_master.sv
module serial_word_master
   import sbm_pkg::*;
#(
   parameter int WORD_W    = 24,
   parameter int NUM_LATCH = 4,
   parameter int HALF      = 50,
   parameter int TGT_W     = $clog2(NUM_LATCH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 rx_mode,
   input  logic [TGT_W-1:0]     target,
   input  logic [WORD_W-1:0]    tx_word,
   input  logic                 irq_clr,
   input  logic                 bus_di,
   output logic                 bus_clk,
   output logic                 bus_do,
   output logic                 bus_oe,
   output logic [NUM_LATCH-1:0] latch,
   output logic                 busy,
   output logic                 irq,
   output logic [WORD_W-1:0]    rx_word
);

   localparam int NBYTES = WORD_W / BYTE_W;

   generate
      if (WORD_W % BYTE_W != 0 || NBYTES < 1)
         $error("WORD_W must be a whole number of bytes");
      if (NUM_LATCH < 2 || (1 << TGT_W) < NUM_LATCH)
         $error("NUM_LATCH must be at least 2 and fit in TGT_W");
      if (HALF < 1)
         $error("HALF must be at least 1");
   endgenerate

   logic              fall_ev, rise_ev;
   logic              load, shift_out, shift_in, strobe, done, rx_act;
   logic [WORD_W-1:0] sr_word;
   logic [TGT_W-1:0]  tgt_q;

   sbm_clkgen #(.HALF(HALF)) u_clkgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_clk (bus_clk),
      .fall_ev (fall_ev),
      .rise_ev (rise_ev)
   );

   sbm_seq #(.WORD_W(WORD_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .fall_ev   (fall_ev),
      .rise_ev   (rise_ev),
      .start     (start),
      .rx_mode   (rx_mode),
      .busy      (busy),
      .oe        (bus_oe),
      .load      (load),
      .shift_out (shift_out),
      .shift_in  (shift_in),
      .strobe    (strobe),
      .done      (done),
      .rx_act    (rx_act)
   );

   sbm_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .par_in    (tx_word),
      .shift_out (shift_out),
      .shift_in  (shift_in),
      .ser_in    (bus_di),
      .ser_out   (bus_do),
      .par_out   (sr_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q   <= '0;
         irq     <= 1'b0;
         rx_word <= '0;
      end else begin
         if (load) tgt_q <= target;
         if (done) irq <= 1'b1;
         else if (irq_clr) irq <= 1'b0;
         if (done && rx_act) rx_word <= sr_word;
      end
   end

   generate
      for (genvar gi = 0; gi < NUM_LATCH; gi++) begin : g_latch
         assign latch[gi] = strobe & (tgt_q == TGT_W'(gi));
      end
   endgenerate

endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
   parameter int HALF      = 50,
   parameter int NUM_LATCH = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_clk,
   input logic                 bus_do,
   input logic                 bus_oe,
   input logic [NUM_LATCH-1:0] latch,
   input logic                 busy,
   input logic                 irq,
   input logic                 irq_clr,
   input logic                 rx_act
);

   logic        seen_q;
   logic [31:0] since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q  <= 1'b1;
         since_q <= '0;
      end else begin
         seen_q <= bus_clk;
         if (bus_clk != seen_q) since_q <= '0;
         else since_q <= since_q + 1'b1;
      end
   end

   assert_clk_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      since_q <= 32'(HALF));

   assert_one_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(latch));

   assert_latch_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|latch) |-> (!bus_oe && busy));

   assert_drive_in_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> busy);

   assert_data_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && $past(bus_oe) && !$fell(bus_clk)) |-> $stable(bus_do));

   assert_rx_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rx_act) |-> !bus_oe);

   assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   assert_end_of_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(|latch) |-> (!busy && irq));

endmodule

bind serial_word_master sbm_checker #(.HALF(HALF), .NUM_LATCH(NUM_LATCH)) u_sbm_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_clk (bus_clk),
   .bus_do  (bus_do),
   .bus_oe  (bus_oe),
   .latch   (latch),
   .busy    (busy),
   .irq     (irq),
   .irq_clr (irq_clr),
   .rx_act  (rx_act)
);

// File: tb/serial_word_master_bench.sv
module serial_word_master_bench;

   localparam int HALF = 3;
   localparam int W    = 24;
   localparam int NL   = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          rx_mode = 1'b0;
   logic [1:0]    target = '0;
   logic [W-1:0]  tx_word = '0;
   logic          irq_clr = 1'b0;
   logic          bus_di = 1'b0;
   logic          bus_clk, bus_do, bus_oe, busy, irq;
   logic [NL-1:0] latch;
   logic [W-1:0]  rx_word;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   serial_word_master #(.WORD_W(W), .NUM_LATCH(NL), .HALF(HALF)) u_serial_word_master (
      .clk(clk), .rst_n(rst_n), .start(start), .rx_mode(rx_mode), .target(target),
      .tx_word(tx_word), .irq_clr(irq_clr), .bus_di(bus_di), .bus_clk(bus_clk),
      .bus_do(bus_do), .bus_oe(bus_oe), .latch(latch), .busy(busy), .irq(irq),
      .rx_word(rx_word)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic xfer(input logic [W-1:0] word, input bit rx, input int tgt,
                       input logic [W-1:0] slave, input bit poke, input bit hold_clr);
      int falls = 0, bad = 0, guard = 0, gap_bad = 0, last_fall = -1, wid = 0;
      logic prev;
      logic [W-1:0] rx_before = rx_word;
      @(negedge clk);
      tx_word = word; rx_mode = rx; target = 2'(tgt); start = 1'b1;
      irq_clr = hold_clr;
      @(negedge clk);
      start = 1'b0;
      prev = bus_clk;
      chk("R7", "busy after start", 32'(busy), 32'd1);
      while (latch == '0 && guard < 2000) begin
         @(negedge clk);
         guard++;
         start = poke && (guard == 5);
         if (poke && guard == 5) begin
            tx_word = ~word; target = 2'(tgt ^ 1); rx_mode = ~rx;
         end
         if (rx && bus_oe !== 1'b0) bad++;
         if (prev == 1'b1 && bus_clk == 1'b0) begin
            falls++;
            if (last_fall >= 0 && guard - last_fall != 2 * HALF) gap_bad++;
            last_fall = guard;
            if (latch == '0) begin
               if (falls > W) bad++;
               else if (!rx) begin
                  if (bus_oe !== 1'b1 || bus_do !== word[W - falls]) bad++;
               end else begin
                  bus_di = slave[W - falls];
               end
            end
         end
         prev = bus_clk;
      end
      start = 1'b0;
      if (rx) chk("R6", "bit errors in receive", 32'(bad), 32'd0);
      else if (poke) chk("R9", "bit errors after ignored start", 32'(bad), 32'd0);
      else chk("R3", "bit errors in transmit", 32'(bad), 32'd0);
      chk("R2", "bus clock gaps off period", 32'(gap_bad), 32'd0);
      chk("R4", "falling edges up to strobe", 32'(falls), 32'(W + 1));
      if (poke) chk("R9", "strobe line", 32'(latch), 32'(1 << tgt));
      else chk("R4", "strobe line", 32'(latch), 32'(1 << tgt));
      chk("R4", "oe at strobe", 32'(bus_oe), 32'd0);
      while (latch != '0 && wid < 100) begin
         wid++;
         @(negedge clk);
      end
      chk("R5", "strobe width", 32'(wid), 32'(HALF));
      chk("R7", "busy after strobe", 32'(busy), 32'd0);
      chk("R8", "irq at completion", 32'(irq), 32'd1);
      if (rx) chk("R6", "received word", 32'(rx_word), 32'(slave));
      else chk("R6", "rx word untouched by transmit", 32'(rx_word), 32'(rx_before));
      @(negedge clk);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk("R8", "irq cleared", 32'(irq), 32'd0);
   endtask

   initial begin
      int t0;
      repeat (3) @(negedge clk);
      chk("R1", "busy", 32'(busy), 32'd0);
      chk("R1", "irq", 32'(irq), 32'd0);
      chk("R1", "oe", 32'(bus_oe), 32'd0);
      chk("R1", "latch", 32'(latch), 32'd0);
      chk("R1", "rx word", 32'(rx_word), 32'd0);
      chk("R1", "bus clock", 32'(bus_clk), 32'd1);
      rst_n = 1'b1;
      // R2: idle period between two falling edges
      @(negedge bus_clk);
      @(negedge clk);
      t0 = 0;
      while (bus_clk == 1'b0) begin @(negedge clk); t0++; end
      while (bus_clk == 1'b1) begin @(negedge clk); t0++; end
      chk("R2", "idle bus clock period", 32'(t0), 32'(2 * HALF));
      for (int tg = 0; tg < NL; tg++) begin
         for (int m = 0; m < 2; m++) begin
            logic [W-1:0] w = 24'h5A3C96 ^ (W'(tg) * 24'h111111) ^ (W'(m) * 24'hF0F0F0);
            xfer(w, bit'(m), tg, ~w ^ 24'h00FF00, 1'b0, 1'b0);
         end
      end
      xfer(24'hFFFFFF, 1'b0, 3, 24'h0, 1'b0, 1'b0);
      xfer(24'h000000, 1'b1, 0, 24'h800001, 1'b0, 1'b0);
      xfer(24'h800001, 1'b0, 1, 24'h0, 1'b0, 1'b0);
      // R9: start, target and data changed mid-transfer
      xfer(24'hC3A551, 1'b0, 2, 24'h0, 1'b1, 1'b0);
      // R8: clear held through completion, set wins
      xfer(24'h123456, 1'b1, 1, 24'hABCDEF, 1'b0, 1'b1);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule